// File: doc/BRIEF.md
# CAN Transmit Mailbox Scheduler

This block sits between software-facing transmit mailboxes and the bit-level CAN transmitter. Each mailbox holds one frame: identifier, extended-format flag, length code and payload. Each mailbox also runs a small state machine with four states: empty, waiting, chosen and on the wire. Every cycle the scheduler decides which waiting mailbox may go next. One of two policies makes that decision. The first picks the lowest arbitration value. The second picks the mailbox whose transmit request came first. When the bus is reported idle, the scheduler hands the chosen frame to the transmitter.

The transmitter reports back with one of three strobes: success, lost arbitration or error. A failed frame either gives up its mailbox or goes back into competition, depending on the automatic-retransmission setting. Software can abort a frame. Software can also clear four sticky status flags per mailbox: complete, success, arbitration lost and error. If several result strobes arrive together, success takes precedence over arbitration loss, and arbitration loss over error.

Top module: `can_txmb_sched`

## Requirements
- R1: After reset every mailbox is empty (state code 0), all status flags are 0 and `tx_start` is 0. The state codes are 0 = empty, 1 = pending, 2 = scheduled and 3 = sending, packed two bits per mailbox with mailbox i at bits [2i+1:2i] of `mb_state`.
- R2: A transmit request to an empty mailbox makes it pending on the next cycle. A request to a mailbox that is not empty is ignored. A configuration write to a mailbox that is not empty is ignored, so the frame already stored is the one that is sent.
- R3: While no mailbox is sending, the highest-priority pending or scheduled mailbox is scheduled one cycle later, and every other contender is held pending. At most one mailbox is ever scheduled or sending.
- R4: With `prio_mode`=0, priority goes to the lowest 29-bit arbitration value. An extended frame uses `id` directly. A standard frame uses `id[10:0]` shifted up by 18 bits. Equal values are won by the lower mailbox index.
- R5: With `prio_mode`=1, mailboxes are served in the order their requests were accepted. Requests accepted in the same cycle are ordered by lower index. A retried frame keeps its original place.
- R6: A scheduled mailbox starts sending on the edge where `bus_idle` is 1. On the following cycle `tx_start` pulses for one cycle, and `tx_mb`, `tx_id`, `tx_ide`, `tx_dlc` and `tx_data` carry that mailbox's index and stored frame.
- R7: A success result empties the sending mailbox and sets its complete and success flags.
- R8: On a failure result, `res_arblost` sets the arbitration-lost flag and `res_err` sets the error flag. If `auto_retx`=0, the mailbox becomes empty and its complete flag is set. If `auto_retx`=1, the mailbox returns to pending and its complete flag stays clear.
- R9: An abort of a pending or scheduled mailbox empties it on the next cycle. It sets the complete flag and leaves the success flag clear.
- R10: An abort of a sending mailbox is held until the result arrives. After a failure that mailbox becomes empty and is not retried.
- R11: A `flag_clr` bit clears that mailbox's four flags. An accepted transmit request also clears them.
- R12: Result strobes that arrive while no mailbox is sending change no state and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prio_mode | input | 1 | 0: lowest arbitration value first; 1: request order |
| auto_retx | input | 1 | Retry failed frames automatically |
| cfg_wr | input | 1 | Frame configuration write strobe |
| cfg_sel | input | 2 | Mailbox index for the configuration write |
| cfg_id | input | 29 | Identifier (standard uses bits 10:0) |
| cfg_ide | input | 1 | 1 = extended identifier |
| cfg_dlc | input | 4 | Data length code |
| cfg_data | input | 64 | Payload |
| tx_req | input | 3 | Per-mailbox transmit request strobes |
| tx_abort | input | 3 | Per-mailbox abort strobes |
| flag_clr | input | 3 | Per-mailbox write-one-to-clear for the flags |
| bus_idle | input | 1 | Bus is idle and a frame may start |
| res_ok | input | 1 | Transmitter reports success |
| res_err | input | 1 | Transmitter reports an error |
| res_arblost | input | 1 | Transmitter reports lost arbitration |
| tx_start | output | 1 | One-cycle start pulse to the transmitter |
| tx_mb | output | 2 | Index of the mailbox being sent |
| tx_id | output | 29 | Identifier of the frame being sent |
| tx_ide | output | 1 | Extended flag of the frame being sent |
| tx_dlc | output | 4 | Length code of the frame being sent |
| tx_data | output | 64 | Payload of the frame being sent |
| mb_state | output | 6 | Per-mailbox state codes |
| st_done | output | 3 | Complete flags |
| st_ok | output | 3 | Success flags |
| st_alost | output | 3 | Arbitration-lost flags |
| st_terr | output | 3 | Error flags |

## Verification
The bench places a standard and an extended identifier so that their values tie only when the standard one is left-aligned. A scheduler that compares raw fields picks the wrong mailbox, and one that breaks ties upward reverses the order. In request-order mode, a frame that lost arbitration must win again over a later request; a design that re-queues retries at the back serves the newer mailbox first. An abort issued while a frame is on the wire must not take the mailbox out of sending, and must suppress the retry. A design that acts on the abort at once shows an early empty state, and one that forgets it starts the frame a second time. The bench also sends stray result strobes, a late configuration write and a repeat request while a mailbox is busy. A design that accepts any of these changes a visible flag, state or transmitted identifier.

// File: rtl/can_txmb_pkg.sv
package can_txmb_pkg;

  typedef enum logic [1:0] {
    MB_EMPTY   = 2'd0,
    MB_PENDING = 2'd1,
    MB_SCHED   = 2'd2,
    MB_SENDING = 2'd3
  } mb_state_e;

  typedef enum logic [1:0] {
    RES_NONE  = 2'd0,
    RES_OK    = 2'd1,
    RES_ALOST = 2'd2,
    RES_TERR  = 2'd3
  } tx_res_e;

endpackage

// File: rtl/can_txmb_slot.sv
module can_txmb_slot
  import can_txmb_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      req,
  input  logic      abort,
  input  logic      clr,
  input  logic      grant,
  input  logic      arb_en,
  input  logic      launch,
  input  logic      auto_retx,
  input  tx_res_e   res,
  output mb_state_e state,
  output logic      req_acc,
  output logic      done_f,
  output logic      ok_f,
  output logic      alost_f,
  output logic      terr_f
);

  mb_state_e nxt;
  logic      abort_hold, hold_nxt;
  logic      set_done, set_ok, set_alost, set_terr;
  logic      wipe;

  assign req_acc = (state == MB_EMPTY) && req;
  assign wipe    = clr || req_acc;

  always_comb begin
    nxt       = state;
    hold_nxt  = abort_hold;
    set_done  = 1'b0;
    set_ok    = 1'b0;
    set_alost = 1'b0;
    set_terr  = 1'b0;
    unique case (state)
      MB_EMPTY: begin
        hold_nxt = 1'b0;
        if (req) nxt = MB_PENDING;
      end
      MB_PENDING: begin
        if (abort) begin
          nxt      = MB_EMPTY;
          set_done = 1'b1;
        end else if (arb_en && grant) begin
          nxt = MB_SCHED;
        end
      end
      MB_SCHED: begin
        if (abort) begin
          nxt      = MB_EMPTY;
          set_done = 1'b1;
        end else if (launch) begin
          nxt = MB_SENDING;
        end else if (arb_en && !grant) begin
          nxt = MB_PENDING;
        end
      end
      MB_SENDING: begin
        if (abort) hold_nxt = 1'b1;
        unique case (res)
          RES_OK: begin
            nxt      = MB_EMPTY;
            set_done = 1'b1;
            set_ok   = 1'b1;
            hold_nxt = 1'b0;
          end
          RES_ALOST, RES_TERR: begin
            set_alost = (res == RES_ALOST);
            set_terr  = (res == RES_TERR);
            hold_nxt  = 1'b0;
            if (auto_retx && !abort_hold && !abort) begin
              nxt = MB_PENDING;
            end else begin
              nxt      = MB_EMPTY;
              set_done = 1'b1;
            end
          end
          default: ;
        endcase
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= MB_EMPTY;
      abort_hold <= 1'b0;
      done_f     <= 1'b0;
      ok_f       <= 1'b0;
      alost_f    <= 1'b0;
      terr_f     <= 1'b0;
    end else begin
      state      <= nxt;
      abort_hold <= hold_nxt;
      done_f     <= (done_f  && !wipe) || set_done;
      ok_f       <= (ok_f    && !wipe) || set_ok;
      alost_f    <= (alost_f && !wipe) || set_alost;
      terr_f     <= (terr_f  && !wipe) || set_terr;
    end
  end

  // R2
  req_to_pending_chk: assert property (@(posedge clk) disable iff (rst)
    (state == MB_EMPTY && req) |=> (state == MB_PENDING));

  // R7
  ok_empties_chk: assert property (@(posedge clk) disable iff (rst)
    (state == MB_SENDING && res == RES_OK) |=> (state == MB_EMPTY && ok_f && done_f));

  // R8
  retry_pending_chk: assert property (@(posedge clk) disable iff (rst)
    (state == MB_SENDING && (res == RES_ALOST || res == RES_TERR) && auto_retx
     && !abort_hold && !abort) |=> (state == MB_PENDING && !done_f));

  // R9
  abort_queued_chk: assert property (@(posedge clk) disable iff (rst)
    ((state == MB_PENDING || state == MB_SCHED) && abort) |=> (state == MB_EMPTY && done_f && !ok_f));

  // R10
  held_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (state == MB_SENDING && abort_hold && (res == RES_ALOST || res == RES_TERR))
    |=> (state == MB_EMPTY));

endmodule

// File: rtl/can_txmb_arb.sv
module can_txmb_arb #(
  parameter int NUM_MB = 3,
  parameter int KEY_W  = 29,
  localparam int SEL_W = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prio_mode,
  input  logic [NUM_MB-1:0] req_acc,
  input  logic [NUM_MB-1:0] cand,
  input  logic [KEY_W-1:0]  key [NUM_MB],
  output logic [NUM_MB-1:0] grant
);

  // older[i][j] = 1 when mailbox i was requested before mailbox j
  logic [NUM_MB-1:0] older [NUM_MB];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_MB; i++) older[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_MB; i++) begin
        for (int j = 0; j < NUM_MB; j++) begin
          if (req_acc[i] && req_acc[j]) older[i][j] <= (i < j);
          else if (req_acc[i])          older[i][j] <= 1'b0;
          else if (req_acc[j])          older[i][j] <= 1'b1;
        end
      end
    end
  end

  logic             found;
  logic [SEL_W-1:0] best;

  always_comb begin
    found = 1'b0;
    best  = '0;
    for (int i = 0; i < NUM_MB; i++) begin
      if (cand[i]) begin
        if (!found) begin
          found = 1'b1;
          best  = SEL_W'(i);
        end else if (prio_mode ? older[i][best] : (key[i] < key[best])) begin
          best = SEL_W'(i);
        end
      end
    end
    grant = found ? (NUM_MB'(1) << best) : '0;
  end

  // R3
  grant_legal_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant) && ((grant & ~cand) == '0));

endmodule

// File: rtl/can_txmb_sched.sv
module can_txmb_sched
  import can_txmb_pkg::*;
#(
  parameter int NUM_MB = 3,
  parameter int ID_W   = 29,
  parameter int STD_W  = 11,
  parameter int DLC_W  = 4,
  parameter int DATA_W = 64,
  localparam int SEL_W = (NUM_MB > 1) ? $clog2(NUM_MB) : 1,
  localparam int SHIFT = ID_W - STD_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                prio_mode,
  input  logic                auto_retx,
  input  logic                cfg_wr,
  input  logic [SEL_W-1:0]    cfg_sel,
  input  logic [ID_W-1:0]     cfg_id,
  input  logic                cfg_ide,
  input  logic [DLC_W-1:0]    cfg_dlc,
  input  logic [DATA_W-1:0]   cfg_data,
  input  logic [NUM_MB-1:0]   tx_req,
  input  logic [NUM_MB-1:0]   tx_abort,
  input  logic [NUM_MB-1:0]   flag_clr,
  input  logic                bus_idle,
  input  logic                res_ok,
  input  logic                res_err,
  input  logic                res_arblost,
  output logic                tx_start,
  output logic [SEL_W-1:0]    tx_mb,
  output logic [ID_W-1:0]     tx_id,
  output logic                tx_ide,
  output logic [DLC_W-1:0]    tx_dlc,
  output logic [DATA_W-1:0]   tx_data,
  output logic [2*NUM_MB-1:0] mb_state,
  output logic [NUM_MB-1:0]   st_done,
  output logic [NUM_MB-1:0]   st_ok,
  output logic [NUM_MB-1:0]   st_alost,
  output logic [NUM_MB-1:0]   st_terr
);

  // frame storage, one entry per mailbox
  logic [ID_W-1:0]   mem_id   [NUM_MB];
  logic              mem_ide  [NUM_MB];
  logic [DLC_W-1:0]  mem_dlc  [NUM_MB];
  logic [DATA_W-1:0] mem_data [NUM_MB];

  mb_state_e         st [NUM_MB];
  logic [ID_W-1:0]   key [NUM_MB];
  logic [NUM_MB-1:0] cand, grant, launch, req_acc, is_send, is_sched, is_empty;
  logic              any_send, launch_any, arb_en, cfg_ok;
  logic [SEL_W-1:0]  launch_idx;
  tx_res_e           res_code;

  always_comb begin
    if (res_ok)           res_code = RES_OK;
    else if (res_arblost) res_code = RES_ALOST;
    else if (res_err)     res_code = RES_TERR;
    else                  res_code = RES_NONE;
  end

  genvar g;
  generate
    for (g = 0; g < NUM_MB; g++) begin : g_mb
      tx_res_e res_g;
      assign is_send[g]  = (st[g] == MB_SENDING);
      assign is_sched[g] = (st[g] == MB_SCHED);
      assign is_empty[g] = (st[g] == MB_EMPTY);
      assign cand[g]     = ((st[g] == MB_PENDING) || is_sched[g]) && !tx_abort[g];
      assign launch[g]   = is_sched[g] && bus_idle && !any_send && !tx_abort[g];
      assign res_g       = is_send[g] ? res_code : RES_NONE;
      assign key[g]      = mem_ide[g] ? mem_id[g] : {mem_id[g][STD_W-1:0], {SHIFT{1'b0}}};
      assign mb_state[2*g +: 2] = st[g];

      can_txmb_slot i_slot (
        .clk       (clk),
        .rst       (rst),
        .req       (tx_req[g]),
        .abort     (tx_abort[g]),
        .clr       (flag_clr[g]),
        .grant     (grant[g]),
        .arb_en    (arb_en),
        .launch    (launch[g]),
        .auto_retx (auto_retx),
        .res       (res_g),
        .state     (st[g]),
        .req_acc   (req_acc[g]),
        .done_f    (st_done[g]),
        .ok_f      (st_ok[g]),
        .alost_f   (st_alost[g]),
        .terr_f    (st_terr[g])
      );
    end
  endgenerate

  assign any_send   = |is_send;
  assign launch_any = |launch;
  assign arb_en     = !any_send && !launch_any;

  can_txmb_arb #(
    .NUM_MB (NUM_MB),
    .KEY_W  (ID_W)
  ) i_arb (
    .clk       (clk),
    .rst       (rst),
    .prio_mode (prio_mode),
    .req_acc   (req_acc),
    .cand      (cand),
    .key       (key),
    .grant     (grant)
  );

  always_comb begin
    launch_idx = '0;
    for (int i = 0; i < NUM_MB; i++)
      if (launch[i]) launch_idx = SEL_W'(i);
  end

  assign cfg_ok = cfg_wr && (int'(cfg_sel) < NUM_MB) && is_empty[cfg_sel];

  always_ff @(posedge clk) begin
    if (cfg_ok) begin
      mem_id[cfg_sel]   <= cfg_id;
      mem_ide[cfg_sel]  <= cfg_ide;
      mem_dlc[cfg_sel]  <= cfg_dlc;
      mem_data[cfg_sel] <= cfg_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_start <= 1'b0;
      tx_mb    <= '0;
      tx_id    <= '0;
      tx_ide   <= 1'b0;
      tx_dlc   <= '0;
      tx_data  <= '0;
    end else begin
      tx_start <= launch_any;
      if (launch_any) begin
        tx_mb   <= launch_idx;
        tx_id   <= mem_id[launch_idx];
        tx_ide  <= mem_ide[launch_idx];
        tx_dlc  <= mem_dlc[launch_idx];
        tx_data <= mem_data[launch_idx];
      end
    end
  end

  // R3
  single_owner_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(is_send | is_sched) <= 1);

  // R6
  start_matches_chk: assert property (@(posedge clk) disable iff (rst)
    tx_start |-> is_send[tx_mb]);

  // R12
  stray_result_chk: assert property (@(posedge clk) disable iff (rst)
    (!any_send && (res_ok || res_err || res_arblost) && flag_clr == '0 && tx_req == '0)
    |=> $stable(st_ok) && $stable(st_alost) && $stable(st_terr));

endmodule

// File: tb/test_can_txmb_sched.sv
`timescale 1ns/1ps
module test_can_txmb_sched;

  logic        clk = 1'b0;
  logic        rst;
  logic        prio_mode, auto_retx, cfg_wr, cfg_ide, bus_idle;
  logic [1:0]  cfg_sel;
  logic [28:0] cfg_id;
  logic [3:0]  cfg_dlc;
  logic [63:0] cfg_data;
  logic [2:0]  tx_req, tx_abort, flag_clr;
  logic        res_ok, res_err, res_arblost;
  logic        tx_start, tx_ide;
  logic [1:0]  tx_mb;
  logic [28:0] tx_id;
  logic [3:0]  tx_dlc;
  logic [63:0] tx_data;
  logic [5:0]  mb_state;
  logic [2:0]  st_done, st_ok, st_alost, st_terr;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  can_txmb_sched i_can_txmb_sched (
    .clk(clk), .rst(rst), .prio_mode(prio_mode), .auto_retx(auto_retx),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_id(cfg_id), .cfg_ide(cfg_ide),
    .cfg_dlc(cfg_dlc), .cfg_data(cfg_data), .tx_req(tx_req), .tx_abort(tx_abort),
    .flag_clr(flag_clr), .bus_idle(bus_idle), .res_ok(res_ok), .res_err(res_err),
    .res_arblost(res_arblost), .tx_start(tx_start), .tx_mb(tx_mb), .tx_id(tx_id),
    .tx_ide(tx_ide), .tx_dlc(tx_dlc), .tx_data(tx_data), .mb_state(mb_state),
    .st_done(st_done), .st_ok(st_ok), .st_alost(st_alost), .st_terr(st_terr)
  );

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] stt(input int i);
    return mb_state[2*i +: 2];
  endfunction

  task automatic wr(input int idx, input logic [28:0] id, input logic ide,
                    input logic [3:0] dlc, input logic [63:0] d);
    cfg_wr = 1'b1; cfg_sel = 2'(idx); cfg_id = id; cfg_ide = ide;
    cfg_dlc = dlc; cfg_data = d;
    tick;
    cfg_wr = 1'b0;
  endtask

  task automatic reqm(input logic [2:0] m);
    tx_req = m;
    tick;
    tx_req = '0;
  endtask

  // kind: 0 success, 1 arbitration lost, 2 error
  task automatic serve(input int exp_mb, input string tag, input int kind);
    int n = 0;
    while (!tx_start && n < 20) begin
      tick;
      n++;
    end
    chk({tag, " start"}, tx_start, 1);
    chk({tag, " tx_mb"}, tx_mb, exp_mb);
    if (kind == 0) res_ok = 1'b1;
    else if (kind == 1) res_arblost = 1'b1;
    else res_err = 1'b1;
    tick;
    res_ok = 1'b0; res_arblost = 1'b0; res_err = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 states", mb_state, 0);
    chk("R1 flags", {st_done, st_ok, st_alost, st_terr}, 0);
    chk("R1 tx_start", tx_start, 0);
  endtask

  task automatic t_basic;
    bus_idle = 1'b0; prio_mode = 1'b0; auto_retx = 1'b0;
    wr(0, 29'h123, 1'b0, 4'd8, 64'hA5A5_0102_0304_5A5A);
    reqm(3'b001);
    chk("R2 pending", stt(0), 1);
    tick;
    chk("R3 scheduled", stt(0), 2);
    bus_idle = 1'b1;
    tick;
    chk("R6 start", tx_start, 1);
    chk("R6 mb", tx_mb, 0);
    chk("R6 id", tx_id, 29'h123);
    chk("R6 ide", tx_ide, 0);
    chk("R6 dlc", tx_dlc, 8);
    chk("R6 data", tx_data, 64'hA5A5_0102_0304_5A5A);
    chk("R6 sending", stt(0), 3);
    tx_req = 3'b001;
    cfg_wr = 1'b1; cfg_sel = 2'd0; cfg_id = 29'h555;
    tick;
    tx_req = '0; cfg_wr = 1'b0;
    chk("R6 one pulse", tx_start, 0);
    chk("R2 busy req ignored", stt(0), 3);
    res_ok = 1'b1;
    tick;
    res_ok = 1'b0;
    chk("R7 empty", stt(0), 0);
    chk("R7 done", st_done[0], 1);
    chk("R7 ok", st_ok[0], 1);
    reqm(3'b001);
    chk("R11 req clears done", st_done[0], 0);
    chk("R11 req clears ok", st_ok[0], 0);
    begin
      int n = 0;
      while (!tx_start && n < 20) begin tick; n++; end
    end
    chk("R2 busy cfg ignored", tx_id, 29'h123);
    serve(0, "R7 resend", 0);
    chk("R7 empty again", stt(0), 0);
    bus_idle = 1'b0;
  endtask

  task automatic t_idmode;
    prio_mode = 1'b0; bus_idle = 1'b0;
    wr(0, 29'h100, 1'b0, 4'd1, 64'h0);
    wr(1, 29'h0400_0000, 1'b1, 4'd2, 64'h1);
    wr(2, 29'h0300_0000, 1'b1, 4'd3, 64'h2);
    reqm(3'b111);
    tick;
    chk("R4 lowest scheduled", stt(2), 2);
    chk("R3 others pending", {stt(1), stt(0)}, {2'd1, 2'd1});
    bus_idle = 1'b1;
    serve(2, "R4 first", 0);
    serve(0, "R4 tie lower index", 0);
    serve(1, "R4 tie higher index", 0);
    bus_idle = 1'b0;
    wr(0, 29'h001, 1'b0, 4'd1, 64'h0);
    wr(1, 29'h0003_FFFF, 1'b1, 4'd1, 64'h0);
    reqm(3'b011);
    tick;
    chk("R4 left-aligned std", stt(1), 2);
    bus_idle = 1'b1;
    serve(1, "R4 ext first", 0);
    serve(0, "R4 std second", 0);
    bus_idle = 1'b0;
  endtask

  task automatic t_order;
    prio_mode = 1'b1; bus_idle = 1'b0;
    wr(0, 29'h001, 1'b0, 4'd0, 64'h0);
    wr(1, 29'h002, 1'b0, 4'd0, 64'h0);
    wr(2, 29'h003, 1'b0, 4'd0, 64'h0);
    reqm(3'b100);
    reqm(3'b001);
    reqm(3'b010);
    bus_idle = 1'b1;
    serve(2, "R5 oldest", 0);
    serve(0, "R5 second", 0);
    serve(1, "R5 third", 0);
    bus_idle = 1'b0;
    reqm(3'b110);
    bus_idle = 1'b1;
    serve(1, "R5 same cycle lower", 0);
    serve(2, "R5 same cycle higher", 0);
    bus_idle = 1'b0;
  endtask

  task automatic t_retry;
    prio_mode = 1'b1; auto_retx = 1'b1; bus_idle = 1'b0;
    reqm(3'b010);
    reqm(3'b001);
    bus_idle = 1'b1;
    serve(1, "R8 first try", 1);
    chk("R8 retry pending", stt(1), 1);
    chk("R8 alost set", st_alost[1], 1);
    chk("R8 no done on retry", st_done[1], 0);
    serve(1, "R5 retry keeps place", 0);
    serve(0, "R5 newer after retry", 0);
    chk("R8 flags kept", {st_ok[1], st_alost[1], st_done[1]}, 3'b111);
    bus_idle = 1'b0; auto_retx = 1'b0;
  endtask

  task automatic t_noretry;
    prio_mode = 1'b0; auto_retx = 1'b0; bus_idle = 1'b1;
    reqm(3'b100);
    serve(2, "R8 err", 2);
    chk("R8 err empty", stt(2), 0);
    chk("R8 err flags", {st_done[2], st_ok[2], st_terr[2]}, 3'b101);
    reqm(3'b001);
    serve(0, "R8 alost", 1);
    chk("R8 alost empty", stt(0), 0);
    chk("R8 alost flags", {st_done[0], st_ok[0], st_alost[0]}, 3'b101);
    bus_idle = 1'b0;
  endtask

  task automatic t_abort;
    bus_idle = 1'b0;
    reqm(3'b010);
    tick;
    chk("R9 sched before abort", stt(1), 2);
    tx_abort = 3'b010;
    tick;
    tx_abort = '0;
    chk("R9 sched aborted", stt(1), 0);
    chk("R9 flags", {st_done[1], st_ok[1]}, 2'b10);
    reqm(3'b100);
    tx_abort = 3'b100;
    tick;
    tx_abort = '0;
    chk("R9 pending aborted", stt(2), 0);
  endtask

  task automatic t_abort_send;
    auto_retx = 1'b1; bus_idle = 1'b1;
    reqm(3'b001);
    begin
      int n = 0;
      while (!tx_start && n < 20) begin tick; n++; end
    end
    tx_abort = 3'b001;
    tick;
    tx_abort = '0;
    chk("R10 still sending", stt(0), 3);
    res_err = 1'b1;
    tick;
    res_err = 1'b0;
    chk("R10 empty no retry", stt(0), 0);
    tick; tick; tick;
    chk("R10 no relaunch", {stt(0), 1'(tx_start)}, 3'b000);
    chk("R10 flags", {st_done[0], st_terr[0]}, 2'b11);
    bus_idle = 1'b0; auto_retx = 1'b0;
  endtask

  task automatic t_flags;
    logic [2:0] keep;
    keep = st_done;
    flag_clr = 3'b001;
    tick;
    flag_clr = '0;
    chk("R11 w1c", {st_done[0], st_ok[0], st_alost[0], st_terr[0]}, 0);
    chk("R11 others kept", st_done[2:1], keep[2:1]);
  endtask

  task automatic t_stray;
    logic [11:0] snap;
    snap = {st_done, st_ok, st_alost, st_terr};
    res_ok = 1'b1; res_err = 1'b1; res_arblost = 1'b1;
    tick;
    res_ok = 1'b0; res_err = 1'b0; res_arblost = 1'b0;
    tick;
    chk("R12 states", mb_state, 0);
    chk("R12 flags", {st_done, st_ok, st_alost, st_terr}, snap);
  endtask

  initial begin
    rst = 1'b1; prio_mode = 1'b0; auto_retx = 1'b0; cfg_wr = 1'b0; cfg_sel = '0;
    cfg_id = '0; cfg_ide = 1'b0; cfg_dlc = '0; cfg_data = '0; tx_req = '0;
    tx_abort = '0; flag_clr = '0; bus_idle = 1'b0; res_ok = 1'b0; res_err = 1'b0;
    res_arblost = 1'b0;
    repeat (3) tick;
    rst = 1'b0;
    tick;
    t_reset;
    t_basic;
    t_idmode;
    t_order;
    t_retry;
    t_noretry;
    t_abort;
    t_abort_send;
    t_flags;
    t_stray;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule